// File: doc/BRIEF.md
# Address-Range Protection Rule Checker

This block decides, for each memory transaction, whether it may proceed or must be refused. It holds a table of twenty protection rules. Each rule names a window of memory in 1 MB steps, an inclusive range of master IDs, a set of ports and the security attributes it covers, plus the verdict it gives. A transaction brings an address, a master ID, a port number and a security attribute. The checker compares it with every valid rule at once. The rule with the lowest number among those that match gives the verdict. When no rule matches, a per-port default mask gives the verdict instead.

Software never reaches the table directly. It fills three staging registers (range, IDs, rule data), then writes a command register holding a rule number and a store strobe, which copies the staged values into that rule. A load strobe works the other way: it copies a rule back into the staging registers, where software can read it. The decision is registered, and it appears one cycle after the transaction is presented.

Top module: `region_guard`

## Requirements
- R1: The table holds 20 rules, numbered 0 to 19. A write to the command register (offset 0) that has bit 5 set copies the staged range, ID and data registers into the rule whose number is in bits 4:0. A rule number of 20 or more leaves the table unchanged.
- R2: A command write that has bit 6 set, and bit 5 clear, loads the selected rule into the three staging registers, so that they can be read back. When bits 5 and 6 are both set, the store alone takes place and the staging registers keep their values.
- R3: The range register (offset 1) holds the low megabyte in bits 11:0 and the high megabyte in bits 23:12. The megabyte of a transaction is address bits 31:20, and it must lie within [low, high], both bounds included.
- R4: The ID register (offset 2) holds the low master ID in bits 11:0 and the high master ID in bits 23:12. The transaction ID must lie within [low, high], both bounds included.
- R5: The data register (offset 3) holds security in bits 1:0, valid in bit 2, the port mask in bits 12:3 and the verdict in bit 13 (0 accepts, 1 rejects). A rule whose valid bit is 0 never matches.
- R6: A rule matches only when the bit of its port mask for the transaction's port is set.
- R7: Security bit 0 of a rule admits secure transactions (txn_nsec=0), and security bit 1 admits non-secure transactions (txn_nsec=1). A rule matches only when the bit for the transaction's attribute is set.
- R8: When several rules match, the matching rule with the lowest number decides the verdict.
- R9: When no rule matches, bit p of the default register (offset 4, 10 bits) gives the verdict for port p, where 1 rejects. Port numbers 10 to 15 are always rejected.
- R10: dec_valid is high in exactly the cycle after a cycle with txn_valid high, and it carries that transaction's verdict in dec_reject. dec_reject is 0 whenever dec_valid is 0.
- R11: After reset every rule is invalid, and the default, staging and command registers all read 0.
- R12: cfg_rdata returns the register at cfg_sel at once. The command register reads back the last rule number written, in bits 4:0, and no strobe bits. Offsets 5 to 7 read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the register at cfg_sel |
| txn_valid | input | 1 | Transaction present |
| txn_addr | input | 32 | Transaction byte address |
| txn_id | input | 12 | Master ID |
| txn_port | input | 4 | Port number |
| txn_nsec | input | 1 | 1 = non-secure, 0 = secure |
| dec_valid | output | 1 | Verdict valid |
| dec_reject | output | 1 | 1 = rejected, 0 = accepted |

## Verification
The bench builds the checker with its default parameters: 20 rules, 10 ports, 12-bit bounds and 12-bit IDs. With these values the command index of 21 is reachable. It lies outside the table, and its low bits alias rule 5. Port numbers 10 to 15 are also reachable, since they fit the 4-bit port field but have no bit in the mask. Both bounds of the address window and of the ID window are hit exactly. The bench sets two rules that overlap with opposite verdicts to test the priority order.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
    localparam int RULE_COUNT = 20;
    localparam int PORT_COUNT = 10;
    localparam int BOUND_W    = 12;
    localparam int ID_W       = 12;
    localparam int ADDR_W     = 32;
    localparam int IDX_W      = 5;
    localparam int PORT_W     = 4;
    localparam int SEC_W      = 2;
    localparam int REG_W      = 32;
    localparam int SEL_W      = 3;

    localparam int MB_LSB     = ADDR_W - BOUND_W;
    localparam int DATA_W     = SEC_W + 1 + PORT_COUNT + 1;
    localparam int CMD_ST_BIT = 5;
    localparam int CMD_LD_BIT = 6;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD   = 3'd0,
        SEL_RANGE = 3'd1,
        SEL_IDS   = 3'd2,
        SEL_DATA  = 3'd3,
        SEL_DFLT  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic                  reject;
        logic [PORT_COUNT-1:0] pmask;
        logic                  valid;
        logic [SEC_W-1:0]      sec;
    } rule_data_t;

    typedef struct packed {
        logic [BOUND_W-1:0] hi_mb;
        logic [BOUND_W-1:0] lo_mb;
        logic [ID_W-1:0]    hi_id;
        logic [ID_W-1:0]    lo_id;
        rule_data_t         data;
    } rule_t;

    function automatic rule_t make_rule(input logic [2*BOUND_W-1:0] rng,
                                        input logic [2*ID_W-1:0] ids,
                                        input logic [DATA_W-1:0] dat);
        rule_t r;
        r.lo_mb = rng[BOUND_W-1:0];
        r.hi_mb = rng[2*BOUND_W-1:BOUND_W];
        r.lo_id = ids[ID_W-1:0];
        r.hi_id = ids[2*ID_W-1:ID_W];
        r.data  = dat;
        return r;
    endfunction
endpackage

// File: rtl/mrg_regfile.sv
module mrg_regfile
    import mrg_pkg::*;
#(
    parameter int NUM_RULES = RULE_COUNT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    input  rule_t                rd_rule,
    output logic                 tbl_we,
    output logic [IDX_W-1:0]     tbl_idx,
    output rule_t                stg_rule,
    output logic [PORT_COUNT-1:0] dflt_mask
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RULES - 1);

    logic [IDX_W-1:0]     cmd_idx;
    logic [2*BOUND_W-1:0] stg_range;
    logic [2*ID_W-1:0]    stg_ids;
    logic [DATA_W-1:0]    stg_data;
    logic                 cmd_hit, idx_ok, ld_en;

    assign cmd_hit = cfg_wr && (cfg_sel == SEL_CMD);
    assign tbl_idx = cfg_wdata[IDX_W-1:0];
    assign idx_ok  = tbl_idx <= LAST_IDX;
    assign tbl_we  = cmd_hit && cfg_wdata[CMD_ST_BIT] && idx_ok;
    assign ld_en   = cmd_hit && !cfg_wdata[CMD_ST_BIT] && cfg_wdata[CMD_LD_BIT] && idx_ok;
    assign stg_rule = make_rule(stg_range, stg_ids, stg_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_idx   <= '0;
            stg_range <= '0;
            stg_ids   <= '0;
            stg_data  <= '0;
            dflt_mask <= '0;
        end else if (ld_en) begin
            cmd_idx   <= tbl_idx;
            stg_range <= {rd_rule.hi_mb, rd_rule.lo_mb};
            stg_ids   <= {rd_rule.hi_id, rd_rule.lo_id};
            stg_data  <= rd_rule.data;
        end else if (cfg_wr) begin
            case (cfg_sel)
                SEL_CMD:   cmd_idx   <= tbl_idx;
                SEL_RANGE: stg_range <= cfg_wdata[2*BOUND_W-1:0];
                SEL_IDS:   stg_ids   <= cfg_wdata[2*ID_W-1:0];
                SEL_DATA:  stg_data  <= cfg_wdata[DATA_W-1:0];
                SEL_DFLT:  dflt_mask <= cfg_wdata[PORT_COUNT-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (cfg_sel)
            SEL_CMD:   cfg_rdata = REG_W'(cmd_idx);
            SEL_RANGE: cfg_rdata = REG_W'(stg_range);
            SEL_IDS:   cfg_rdata = REG_W'(stg_ids);
            SEL_DATA:  cfg_rdata = REG_W'(stg_data);
            SEL_DFLT:  cfg_rdata = REG_W'(dflt_mask);
            default:   cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mrg_table.sv
module mrg_table
    import mrg_pkg::*;
#(
    parameter int NUM_RULES = RULE_COUNT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [IDX_W-1:0]      idx,
    input  rule_t                 wr_rule,
    output rule_t                 rd_rule,
    output rule_t [NUM_RULES-1:0] rules
);
    for (genvar i = 0; i < NUM_RULES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                rules[i] <= '0;
            else if (we && (idx == IDX_W'(i)))
                rules[i] <= wr_rule;
        end
    end

    always_comb begin
        rd_rule = '0;
        for (int i = 0; i < NUM_RULES; i++)
            if (idx == IDX_W'(i))
                rd_rule = rules[i];
    end
endmodule

// File: rtl/mrg_match.sv
module mrg_match
    import mrg_pkg::*;
#(
    parameter int NUM_RULES = RULE_COUNT
) (
    input  rule_t [NUM_RULES-1:0] rules,
    input  logic [PORT_COUNT-1:0] dflt_mask,
    input  logic [ADDR_W-1:0]     txn_addr,
    input  logic [ID_W-1:0]       txn_id,
    input  logic [PORT_W-1:0]     txn_port,
    input  logic                  txn_nsec,
    output logic                  verdict
);
    localparam int PWIDE = 2 ** PORT_W;

    logic [BOUND_W-1:0]   mb;
    logic [NUM_RULES-1:0] hit;
    logic [PWIDE-1:0]     dflt_wide;
    logic                 any_hit, hit_rej;

    assign mb = txn_addr[ADDR_W-1:MB_LSB];
    assign dflt_wide = {{(PWIDE-PORT_COUNT){1'b1}}, dflt_mask};

    for (genvar i = 0; i < NUM_RULES; i++) begin : g_cmp
        logic [PWIDE-1:0] mask_wide;
        logic in_mb, in_id, port_ok, sec_ok;
        assign mask_wide = PWIDE'(rules[i].data.pmask);
        assign in_mb   = (mb >= rules[i].lo_mb) && (mb <= rules[i].hi_mb);
        assign in_id   = (txn_id >= rules[i].lo_id) && (txn_id <= rules[i].hi_id);
        assign port_ok = mask_wide[txn_port];
        assign sec_ok  = rules[i].data.sec[txn_nsec];
        assign hit[i]  = rules[i].data.valid && in_mb && in_id && port_ok && sec_ok;
    end

    always_comb begin
        any_hit = 1'b0;
        hit_rej = 1'b0;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit = 1'b1;
                hit_rej = rules[i].data.reject;
            end
        end
    end

    assign verdict = any_hit ? hit_rej : dflt_wide[txn_port];
endmodule

// File: rtl/region_guard.sv
module region_guard
    import mrg_pkg::*;
#(
    parameter int NUM_RULES = RULE_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              txn_valid,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [ID_W-1:0]   txn_id,
    input  logic [PORT_W-1:0] txn_port,
    input  logic              txn_nsec,
    output logic              dec_valid,
    output logic              dec_reject
);
    rule_t                 rd_rule, stg_rule;
    rule_t [NUM_RULES-1:0] rules;
    logic                  tbl_we, verdict;
    logic [IDX_W-1:0]      tbl_idx;
    logic [PORT_COUNT-1:0] dflt_mask;

    mrg_regfile #(.NUM_RULES(NUM_RULES)) u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rd_rule(rd_rule),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .stg_rule(stg_rule),
        .dflt_mask(dflt_mask)
    );

    mrg_table #(.NUM_RULES(NUM_RULES)) u_table (
        .clk(clk), .rst(rst), .we(tbl_we), .idx(tbl_idx),
        .wr_rule(stg_rule), .rd_rule(rd_rule), .rules(rules)
    );

    mrg_match #(.NUM_RULES(NUM_RULES)) u_match (
        .rules(rules), .dflt_mask(dflt_mask), .txn_addr(txn_addr),
        .txn_id(txn_id), .txn_port(txn_port), .txn_nsec(txn_nsec),
        .verdict(verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_reject <= 1'b0;
        end else begin
            dec_valid  <= txn_valid;
            dec_reject <= txn_valid && verdict;
        end
    end
endmodule

// File: rtl/mrg_guard_chk.sv
module mrg_guard_chk
    import mrg_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  txn_valid,
    input logic [PORT_W-1:0]     txn_port,
    input logic                  dec_valid,
    input logic                  dec_reject,
    input logic                  tbl_we,
    input logic [PORT_COUNT-1:0] dflt_mask
);
    localparam int PWIDE = 2 ** PORT_W;
    logic             stored_any;
    logic [PWIDE-1:0] dflt_wide;
    logic             port_real;

    assign dflt_wide = PWIDE'(dflt_mask);
    assign port_real = txn_port < PORT_W'(PORT_COUNT);

    always_ff @(posedge clk) begin
        if (rst) stored_any <= 1'b0;
        else if (tbl_we) stored_any <= 1'b1;
    end

    // R10
    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        txn_valid |=> dec_valid);
    // R10
    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !txn_valid |=> (!dec_valid && !dec_reject));
    // R9
    p_badport_r9: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !port_real) |=> dec_reject);
    // R11: with an empty table only the default mask decides
    p_empty_accept_r11: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !stored_any && port_real && !dflt_wide[txn_port]) |=> !dec_reject);
    // R9
    p_empty_reject_r9: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !stored_any && dflt_wide[txn_port]) |=> dec_reject);
endmodule

bind region_guard mrg_guard_chk u_chk (
    .clk(clk), .rst(rst), .txn_valid(txn_valid), .txn_port(txn_port),
    .dec_valid(dec_valid), .dec_reject(dec_reject), .tbl_we(tbl_we),
    .dflt_mask(dflt_mask)
);

// File: tb/region_guard_tb.sv
module region_guard_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        txn_valid = 1'b0;
    logic [31:0] txn_addr = '0;
    logic [11:0] txn_id = '0;
    logic [3:0]  txn_port = '0;
    logic        txn_nsec = 1'b0;
    logic        dec_valid, dec_reject;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    region_guard u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_valid(txn_valid),
        .txn_addr(txn_addr), .txn_id(txn_id), .txn_port(txn_port),
        .txn_nsec(txn_nsec), .dec_valid(dec_valid), .dec_reject(dec_reject)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] sel, input logic [31:0] exp,
                            input string tag);
        cfg_sel = sel;
        #1;
        check(cfg_rdata === exp, tag, cfg_rdata, exp);
        @(negedge clk);
    endtask

    task automatic prog(input int idx, input logic [11:0] lo, input logic [11:0] hi,
                        input logic [11:0] idlo, input logic [11:0] idhi,
                        input logic [1:0] sec, input logic vld,
                        input logic [9:0] pmask, input logic rej);
        wr(3'd1, {8'd0, hi, lo});
        wr(3'd2, {8'd0, idhi, idlo});
        wr(3'd3, {18'd0, rej, pmask, vld, sec});
        wr(3'd0, 32'(idx) | 32'h20);
    endtask

    // driver: present one transaction and push its expected verdict
    task automatic send(input logic [31:0] a, input logic [11:0] id,
                        input logic [3:0] port, input logic ns,
                        input bit exp, input string tag);
        txn_valid = 1'b1; txn_addr = a; txn_id = id; txn_port = port; txn_nsec = ns;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        txn_valid = 1'b0;
    endtask

    // monitor: compare each verdict against the scoreboard (R10 timing)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (dec_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 verdict without transaction", 32'd1, 32'd0);
                end else begin
                    automatic bit e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(dec_reject === e, t, 32'(dec_reject), 32'(e));
                end
            end else if (dec_reject !== 1'b0) begin
                check(1'b0, "R10 reject while idle", 32'(dec_reject), 32'd0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        rd_check(3'd4, 32'h0, "R11 default after reset");
        rd_check(3'd3, 32'h0, "R11 data stage after reset");
        rd_check(3'd0, 32'h0, "R11 command after reset");
        send(32'h0050_0000, 12'h005, 4'd0, 1'b0, 1'b0, "R11 empty table accepts");
        // R9 default reject
        wr(3'd4, 32'h3FF);
        rd_check(3'd4, 32'h3FF, "R9 default readback");
        send(32'h0050_0000, 12'h005, 4'd3, 1'b0, 1'b1, "R9 default rejects");
        // R3 / R4 window edges
        prog(0, 12'h001, 12'h003, 12'h010, 12'h020, 2'b11, 1'b1, 10'h3FF, 1'b0);
        send(32'h0010_0000, 12'h010, 4'd0, 1'b0, 1'b0, "R3 low bound");
        send(32'h003F_FFFF, 12'h020, 4'd9, 1'b1, 1'b0, "R3 high bound inclusive");
        send(32'h0040_0000, 12'h015, 4'd0, 1'b0, 1'b1, "R3 above high");
        send(32'h000F_FFFF, 12'h015, 4'd0, 1'b0, 1'b1, "R3 below low");
        send(32'h0020_0000, 12'h021, 4'd0, 1'b0, 1'b1, "R4 id above");
        send(32'h0020_0000, 12'h00F, 4'd0, 1'b0, 1'b1, "R4 id below");
        // R6 / R7
        prog(0, 12'h001, 12'h003, 12'h010, 12'h020, 2'b01, 1'b1, 10'h001, 1'b0);
        send(32'h0020_0000, 12'h015, 4'd0, 1'b0, 1'b0, "R6 masked port accepted");
        send(32'h0020_0000, 12'h015, 4'd1, 1'b0, 1'b1, "R6 port outside mask");
        send(32'h0020_0000, 12'h015, 4'd0, 1'b1, 1'b1, "R7 non-secure refused");
        prog(0, 12'h001, 12'h003, 12'h010, 12'h020, 2'b10, 1'b1, 10'h001, 1'b0);
        send(32'h0020_0000, 12'h015, 4'd0, 1'b1, 1'b0, "R7 non-secure admitted");
        send(32'h0020_0000, 12'h015, 4'd0, 1'b0, 1'b1, "R7 secure refused");
        // R8 priority, R5 reject verdict
        wr(3'd4, 32'h0);
        prog(4, 12'h200, 12'h2FF, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b1);
        prog(3, 12'h200, 12'h200, 12'h000, 12'hFFF, 2'b11, 1'b1, 10'h3FF, 1'b0);
        send(32'h2000_0000, 12'h123, 4'd2, 1'b0, 1'b0, "R8 lower rule wins");
        send(32'h2010_0000, 12'h123, 4'd2, 1'b0, 1'b1, "R5 reject verdict");
        // R1 out-of-range index ignored
        wr(3'd4, 32'h3FF);
        wr(3'd1, {8'd0, 12'h300, 12'h300});
        wr(3'd2, {8'd0, 12'hFFF, 12'h000});
        wr(3'd3, {18'd0, 1'b0, 10'h3FF, 1'b1, 2'b11});
        wr(3'd0, 32'd21 | 32'h20);
        send(32'h3000_0000, 12'h001, 4'd5, 1'b0, 1'b1, "R1 index 21 ignored");
        // R5 invalid rule never matches
        prog(6, 12'h300, 12'h300, 12'h000, 12'hFFF, 2'b11, 1'b0, 10'h3FF, 1'b0);
        send(32'h3000_0000, 12'h001, 4'd5, 1'b0, 1'b1, "R5 invalid rule ignored");
        // R2 readback
        wr(3'd1, 32'h0); wr(3'd2, 32'h0); wr(3'd3, 32'h0);
        wr(3'd0, 32'd4 | 32'h40);
        rd_check(3'd1, 32'h002F_F200, "R2 range readback");
        rd_check(3'd2, 32'h00FF_F000, "R2 id readback");
        rd_check(3'd3, 32'h0000_3FFF, "R2 data readback");
        rd_check(3'd0, 32'h4, "R12 command readback");
        // R2 store wins over load
        wr(3'd0, 32'd3 | 32'h60);
        rd_check(3'd1, 32'h002F_F200, "R2 staging kept on dual strobe");
        wr(3'd4, 32'h0);
        send(32'h2000_0000, 12'h123, 4'd2, 1'b0, 1'b1, "R2 rule 3 overwritten");
        // R9 ports beyond mask
        send(32'h0500_0000, 12'h001, 4'd12, 1'b0, 1'b1, "R9 port 12 rejected");
        send(32'h0500_0000, 12'h001, 4'd10, 1'b0, 1'b1, "R9 port 10 rejected");
        send(32'h0500_0000, 12'h001, 4'd9, 1'b0, 1'b0, "R9 port 9 default accept");
        // R12 unmapped offset
        wr(3'd6, 32'hFFFF_FFFF);
        rd_check(3'd6, 32'h0, "R12 unmapped reads zero");
        rd_check(3'd4, 32'h0, "R12 unmapped write ignored");
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all verdicts returned", 32'(exp_q.size()), 32'd0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule